// File: doc/BRIEF.md
# Self-Terminating 16-Bit Serial Word Receiver

This block is the write-only serial front end of a single-target converter-style peripheral. A host lowers an active-low select, then presents one data bit per serial clock period; the block takes a bit on every falling serial clock edge. The serial clock, select and data pins are sampled by a faster system clock and pass through synchronisers before any edge is detected.

The block collects the word itself. Once the sixteenth bit has arrived it publishes the complete word and raises a one-cycle valid strobe for the downstream decode and update logic. It does not wait for select to return high. The block then ignores the serial clock and data pins until select falls again. Select may rise at any moment after completion with no effect. If select rises before sixteen bits have arrived, the partial word is dropped without a strobe.

Top module: `str_rx`

## Requirements
- R1: After synchronous reset, `word_o` is 0 and `word_vld_o` is 0.
- R2: The bits taken on the first 16 falling edges of `sclk_i` after `csn_i` falls form `word_o`. The first bit taken is bit 15 and the last bit taken is bit 0.
- R3: Each completed frame gives exactly one `word_vld_o` pulse, and the pulse is exactly one system clock cycle long.
- R4: The pulse and the new `word_o` appear within 8 system clock cycles after the 16th falling edge of `sclk_i`, while `csn_i` is still low.
- R5: Falling edges of `sclk_i` and values on `din_i` after the 16th edge of a frame neither change `word_o` nor produce another pulse.
- R6: If `csn_i` rises before 16 bits have been taken, no pulse is produced and `word_o` keeps its previous value.
- R7: A new falling edge of `csn_i` ends the lockout. The next frame is captured from fresh bits, with nothing carried over from an aborted or locked frame.
- R8: `word_o` changes only in the cycle in which `word_vld_o` is high. Otherwise it holds its value.
- R9: A rise of `csn_i` after a frame has completed changes neither `word_o` nor `word_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock; a bit is taken on its falling edge |
| csn_i | input | 1 | Active-low frame select |
| din_i | input | 1 | Serial data, most significant bit first |
| word_o | output | 16 | Last completed word |
| word_vld_o | output | 1 | One-cycle strobe marking a new word |

## Verification
The hardest condition to reach is the lockout: serial clock edges arriving while select is still low and the word is already complete. The bench creates it by driving frames of 24 bits and by pulsing the clock after completion before releasing select. It then checks that the word and the pulse count are unchanged. It also aborts a frame at 10 bits and follows it at once with a full frame, which shows that no leftover bits reach the next word.

// File: rtl/str_pkg.sv
package str_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } cap_state_t;
endpackage

// File: rtl/str_sync.sv
module str_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/str_edge.sv
module str_edge #(
  parameter int               WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= lvl_i;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign rise_o[b] = ~prev_q[b] &  lvl_i[b];
    assign fall_o[b] =  prev_q[b] & ~lvl_i[b];
  end
endmodule

// File: rtl/str_capture.sv
module str_capture
  import str_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              vld_o,
  output cap_state_t        state_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  cap_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] sh_nxt;

  assign sh_nxt = {sh_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      word_o  <= '0;
      vld_o   <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SHIFT;
            cnt_q   <= '0;
            sh_q    <= '0;
          end
        end
        ST_SHIFT: begin
          if (abort_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else if (shift_i) begin
            sh_q <= sh_nxt;
            if (cnt_q == LAST) begin
              word_o  <= sh_nxt;
              vld_o   <= 1'b1;
              state_q <= ST_DONE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_DONE: begin
          if (start_i) begin
            state_q <= ST_SHIFT;
            cnt_q   <= '0;
            sh_q    <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/str_rx.sv
module str_rx
  import str_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              din_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int PIN_N = 3;

  logic [PIN_N-1:0] pins_s;
  logic [1:0]       rise_v;
  logic [1:0]       fall_v;
  logic             sclk_fall;
  logic             csn_fall;
  logic             csn_rise;
  cap_state_t       cap_state;

  str_sync #(
    .WIDTH  (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i({csn_i, sclk_i, din_i}),
    .q_o(pins_s)
  );

  str_edge #(
    .WIDTH  (2),
    .RST_VAL(2'b11)
  ) u_edge (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (pins_s[2:1]),
    .rise_o(rise_v),
    .fall_o(fall_v)
  );

  assign csn_fall  = fall_v[1];
  assign csn_rise  = rise_v[1];
  assign sclk_fall = fall_v[0] & ~pins_s[2];

  str_capture #(
    .WORD_W(WORD_W)
  ) u_cap (
    .clk    (clk),
    .rst    (rst),
    .start_i(csn_fall),
    .abort_i(csn_rise),
    .shift_i(sclk_fall),
    .bit_i  (pins_s[0]),
    .word_o (word_o),
    .vld_o  (word_vld_o),
    .state_o(cap_state)
  );
endmodule

// File: rtl/str_rx_chk.sv
module str_rx_chk
  import str_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] word_o,
  input logic              word_vld_o,
  input cap_state_t        cap_state,
  input logic              sclk_fall,
  input logic              csn_rise,
  input logic              csn_fall
);
  // R3
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |=> !word_vld_o);

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !word_vld_o |-> $stable(word_o));

  // R5
  lockout_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_state == ST_DONE && !csn_fall && sclk_fall) |=> (!word_vld_o && cap_state == ST_DONE));

  // R6
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_state == ST_SHIFT && csn_rise) |=> (!word_vld_o && cap_state == ST_IDLE));

  // R9
  late_release_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_state == ST_DONE && csn_rise) |=> !word_vld_o);

  // R3
  vld_enters_done_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |-> cap_state == ST_DONE);
endmodule

bind str_rx str_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .word_o    (word_o),
  .word_vld_o(word_vld_o),
  .cap_state (cap_state),
  .sclk_fall (sclk_fall),
  .csn_rise  (csn_rise),
  .csn_fall  (csn_fall)
);

// File: tb/str_rx_bench.sv
`timescale 1ns/1ps
module str_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk_i = 1'b1;
  logic        csn_i = 1'b1;
  logic        din_i = 1'b0;
  logic [15:0] word_o;
  logic        word_vld_o;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  int run_len = 0;
  int max_run = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  str_rx u_str_rx (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .csn_i(csn_i),
    .din_i(din_i), .word_o(word_o), .word_vld_o(word_vld_o)
  );

  always @(negedge clk) begin
    if (word_vld_o) begin
      if (run_len == 0) pulses++;
      run_len++;
      if (run_len > max_run) max_run = run_len;
    end else begin
      run_len = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      din_i = v[i];
      wait_clk(4);
      sclk_i = 1'b0;
      wait_clk(4);
      sclk_i = 1'b1;
    end
  endtask

  task automatic open_frame();
    csn_i = 1'b0;
    wait_clk(6);
  endtask

  task automatic close_frame();
    wait_clk(4);
    csn_i = 1'b1;
    wait_clk(8);
  endtask

  task automatic t_reset();
    check("R1 word", word_o, 0);
    check("R1 vld", word_vld_o, 0);
  endtask

  task automatic t_word(input logic [15:0] w);
    int p0 = pulses;
    open_frame();
    send_bits({16'h0, w}, 16);
    wait_clk(8);
    check("R4 pulse before release", pulses, p0 + 1);
    check("R2 word", word_o, w);
    close_frame();
    check("R3 one pulse", pulses, p0 + 1);
  endtask

  task automatic t_overrun();
    int p0 = pulses;
    open_frame();
    send_bits(32'h003C967E, 24);
    wait_clk(8);
    check("R5 first 16 kept", word_o, 16'h3C96);
    check("R5 no extra pulse", pulses, p0 + 1);
    close_frame();
    check("R9 release no change", word_o, 16'h3C96);
    check("R9 release no pulse", pulses, p0 + 1);
  endtask

  task automatic t_abort_then_new();
    int p0 = pulses;
    logic [15:0] prev = word_o;
    open_frame();
    send_bits(32'h000002AB, 10);
    close_frame();
    check("R6 no pulse", pulses, p0);
    check("R6 word held", word_o, prev);
    open_frame();
    send_bits(32'h00001234, 16);
    wait_clk(8);
    check("R7 fresh word", word_o, 16'h1234);
    close_frame();
    check("R7 one pulse", pulses, p0 + 1);
  endtask

  task automatic t_idle_hold();
    logic [15:0] prev = word_o;
    int p0 = pulses;
    sclk_i = 1'b0; wait_clk(5); sclk_i = 1'b1; wait_clk(5);
    wait_clk(40);
    check("R8 idle hold", word_o, prev);
    check("R8 no pulse idle", pulses, p0);
  endtask

  task automatic t_relock();
    int p0 = pulses;
    open_frame();
    send_bits(32'h0000C0DE, 16);
    send_bits(32'h0000FFFF, 16);
    wait_clk(8);
    check("R5 pulses after lock", pulses, p0 + 1);
    check("R5 word after lock", word_o, 16'hC0DE);
    close_frame();
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    t_word(16'hA5C3);
    t_word(16'h0001);
    t_word(16'hFFFF);
    t_overrun();
    t_abort_then_new();
    t_idle_hold();
    t_relock();
    check("R3 pulse width", max_run, 1);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_clk(100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule